// File: doc/BRIEF.md
# Eight-channel down-counting timer bank

The block holds a set of independent down-counting timers behind a minimal register bus (valid, write, byte address, data). Each channel owns a control byte and a count word. Software stops a channel, loads a count, then starts it in one of three modes:

- free-running, where the counter wraps through zero and keeps going, so an inverted readback gives an up-counter;
- one-shot, where the channel stops itself at zero;
- periodic, where the channel reloads the last value written to its count word.

Reaching zero sets a sticky pending flag. That flag drives the channel's own interrupt line until software clears it through a shared status word.

The count word does two jobs. A write sets both the live counter and the reload value. A read returns the live counter. Read data is registered and appears one clock after the request. Every register is 32 bits wide on the bus. Every clock is one counting tick.

Top module: `tmr_bank`

## Requirements
- R1: After synchronous reset every counter, reload value, enable bit, mode field and pending flag is zero, and all irq lines are low.
- R2: Byte address n*8 selects channel n's control and n*8+4 its count, for n in 0..7. Address 0x40 is the status word, with bit n for channel n. A read request returns its data on bus_rdata one clock later. A read of any other address, including one with address bits [1:0] non-zero, returns zero.
- R3: A control write uses only bus_wdata[7:0]. Bit 0 is enable. Bits [5:4] are the mode: 0 free-run, 1 one-shot, 2 periodic, 3 behaves as free-run. A control read returns enable in bit 0 and mode in bits [5:4], with every other bit zero. Writing 0 stops the channel.
- R4: A count write loads the live counter and the reload value with bus_wdata, even while the channel runs. In that cycle it takes priority over counting.
- R5: An enabled counter above one drops by one every clock. A disabled counter holds its value.
- R6: Expiry is the clock on which an enabled counter holding 1 moves to 0, and it sets the channel's pending flag. In free-run mode a counter at 0 next reads all ones.
- R7: In one-shot mode, expiry leaves the counter at 0 and clears the enable bit. An enabled one-shot channel already at 0 stays at 0 and clears its enable bit without setting pending.
- R8: In periodic mode the counter loads the reload value instead of 0. This happens when it holds 1, which also counts as expiry, and when it holds 0. A reload of N therefore gives the sequence N, N-1, ..., 1, N.
- R9: irq[n] is channel n's pending flag. The flag stays set until a write to 0x40 with bit n set. An expiry in the same cycle as the clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the counting tick |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after request |
| irq | output | 8 | Per-channel pending interrupt |

## Verification
The bench targets the zero boundary in each mode:

- The free-run wrap from 0 to all ones. A design that stopped or reloaded there would return 0 instead of FFFFFFFF.
- The periodic N..1,N sequence. A design that let zero show, or reloaded a cycle late, would return 0 in the sequence.
- One-shot self-disable. A wrong design would keep counting, wrap, or leave the enable bit set in the control readback.

It also covers these cases:

- A count write to a running channel must show up in the very next read.
- A status clear must touch only the selected flag.
- Unmapped and misaligned reads must return zero.

Random mixed traffic against a bench-side model catches a wrong priority between a count write and counting, or between a flag clear and a new expiry.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_ONE  = 2'd1,
    MODE_PER  = 2'd2,
    MODE_RSV  = 2'd3
  } tmr_mode_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MODE_LSB = 4;
  localparam int CH_STRIDE    = 8;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_en,
  input  tmr_mode_e        ctl_mode,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             en,
  output tmr_mode_e        mode,
  output logic             pend
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] nxt;
  logic             at_edge;
  logic             hit;
  logic             stop_now;

  assign at_edge  = (cnt <= ONE);
  assign hit      = en && (cnt == ONE);
  assign stop_now = en && (mode == MODE_ONE) && at_edge;

  always_comb begin
    case (mode)
      MODE_PER: nxt = at_edge ? reload : cnt - ONE;
      MODE_ONE: nxt = at_edge ? '0 : cnt - ONE;
      default:  nxt = cnt - ONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      reload <= '0;
      en     <= 1'b0;
      mode   <= MODE_FREE;
      pend   <= 1'b0;
    end else begin
      if (ctl_wr) begin
        en   <= ctl_en;
        mode <= ctl_mode;
      end else if (stop_now) begin
        en <= 1'b0;
      end
      if (cnt_wr) begin
        cnt    <= wdata;
        reload <= wdata;
      end else if (en) begin
        cnt <= nxt;
      end
      pend <= hit | (pend & ~clr);
    end
  end

  // R6
  exp_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == ONE) |=> pend);
  // R9
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> pend);
  // R4
  load_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt == $past(wdata)));
  // R5
  dec_chk: assert property (@(posedge clk) disable iff (rst)
    (en && cnt > ONE && !cnt_wr) |=> (cnt == $past(cnt) - ONE));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !cnt_wr) |=> $stable(cnt));
  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mode == MODE_ONE && cnt == ONE && !cnt_wr && !ctl_wr)
      |=> (!en && cnt == '0));
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int          NCH      = 8,
  parameter int          CNT_W    = 32,
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  STAT_OFF = 8'h40
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_req,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NCH-1:0][CNT_W-1:0]  cnt_all,
  input  logic [NCH-1:0]             en_all,
  input  logic [NCH-1:0][1:0]        mode_all,
  input  logic [NCH-1:0]             pend_all,
  output logic [CNT_W-1:0]           rdata
);
  localparam int CH_BITS = $clog2(NCH);
  localparam logic [ADDR_W-1:0] CH_SPAN = ADDR_W'(NCH * CH_STRIDE);
  localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_OFF);

  logic [CNT_W-1:0]   rd_nxt;
  logic [CH_BITS-1:0] ch;
  logic               mapped;

  assign ch = addr[CH_BITS+2:3];

  always_comb begin
    rd_nxt = '0;
    mapped = 1'b0;
    if (addr[1:0] == 2'b00) begin
      if (addr == STAT_A) begin
        rd_nxt = CNT_W'(pend_all);
        mapped = 1'b1;
      end else if (addr < CH_SPAN) begin
        mapped = 1'b1;
        if (addr[2]) rd_nxt = cnt_all[ch];
        else         rd_nxt = CNT_W'({2'b00, mode_all[ch], 3'b000, en_all[ch]});
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_req) rdata <= rd_nxt;
  end

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !mapped) |=> (rdata == '0));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int          NCH      = 8,
  parameter int          CNT_W    = 32,
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  STAT_OFF = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    irq
);
  localparam int CH_BITS = $clog2(NCH);
  localparam logic [ADDR_W-1:0] CH_SPAN = ADDR_W'(NCH * CH_STRIDE);
  localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_OFF);

  logic                      wr;
  logic                      in_ch;
  logic                      stat_wr;
  logic [CH_BITS-1:0]        ch_idx;
  logic [NCH-1:0][CNT_W-1:0] cnt_all;
  logic [NCH-1:0]            en_all;
  logic [NCH-1:0][1:0]       mode_all;
  logic [NCH-1:0]            pend_all;

  assign wr      = bus_valid && bus_write;
  assign in_ch   = (bus_addr[1:0] == 2'b00) && (bus_addr < CH_SPAN);
  assign stat_wr = wr && (bus_addr == STAT_A);
  assign ch_idx  = bus_addr[CH_BITS+2:3];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic      sel;
    tmr_mode_e m_out;
    assign sel = wr && in_ch && (ch_idx == CH_BITS'(i));
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .ctl_wr   (sel && !bus_addr[2]),
      .ctl_en   (bus_wdata[CTL_EN_BIT]),
      .ctl_mode (tmr_mode_e'(bus_wdata[CTL_MODE_LSB+1:CTL_MODE_LSB])),
      .cnt_wr   (sel && bus_addr[2]),
      .wdata    (bus_wdata),
      .clr      (stat_wr && bus_wdata[i]),
      .cnt      (cnt_all[i]),
      .en       (en_all[i]),
      .mode     (m_out),
      .pend     (pend_all[i])
    );
    assign mode_all[i] = m_out;
  end

  assign irq = pend_all;

  tmr_rdmux #(
    .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .STAT_OFF(STAT_OFF)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (bus_valid && !bus_write),
    .addr     (bus_addr),
    .cnt_all  (cnt_all),
    .en_all   (en_all),
    .mode_all (mode_all),
    .pend_all (pend_all),
    .rdata    (bus_rdata)
  );
endmodule

// File: tb/test_tmr_bank.sv
module test_tmr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit chk_irq = 1'b0;
  bit done = 1'b0;

  tmr_bank i_tmr_bank (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  // Reference model, written from the requirements.
  logic [31:0] m_cnt [8];
  logic [31:0] m_rel [8];
  logic        m_en  [8];
  logic [1:0]  m_mode[8];
  logic [7:0]  m_pend;
  logic [31:0] m_rd;

  function automatic logic [31:0] mdl_read(logic [7:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a == 8'h40) return {24'h0, m_pend};
    if (a < 8'd64) begin
      if (a[2]) return m_cnt[a[5:3]];
      return {26'h0, m_mode[a[5:3]], 3'b000, m_en[a[5:3]]};
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) begin
        m_cnt[i] <= '0; m_rel[i] <= '0; m_en[i] <= 1'b0; m_mode[i] <= '0;
      end
      m_pend <= '0;
      m_rd   <= '0;
    end else begin
      if (bus_valid && !bus_write) m_rd <= mdl_read(bus_addr);
      for (int i = 0; i < 8; i++) begin
        logic [31:0] nc;
        logic        ne;
        logic        np;
        nc = m_cnt[i];
        ne = m_en[i];
        np = m_pend[i];
        if (bus_valid && bus_write && bus_addr == 8'h40 && bus_wdata[i]) np = 1'b0;
        if (m_en[i]) begin
          if (m_cnt[i] == 32'd1) begin
            np = 1'b1;
            if (m_mode[i] == 2'd2)      nc = m_rel[i];
            else                        nc = 32'd0;
            if (m_mode[i] == 2'd1)      ne = 1'b0;
          end else if (m_cnt[i] == 32'd0) begin
            if (m_mode[i] == 2'd2)      nc = m_rel[i];
            else if (m_mode[i] == 2'd1) ne = 1'b0;
            else                        nc = 32'hFFFF_FFFF;
          end else begin
            nc = m_cnt[i] - 32'd1;
          end
        end
        if (bus_valid && bus_write && bus_addr == 8'(i*8+4)) begin
          nc = bus_wdata;
          m_rel[i] <= bus_wdata;
        end
        if (bus_valid && bus_write && bus_addr == 8'(i*8)) begin
          ne = bus_wdata[0];
          m_mode[i] <= bus_wdata[5:4];
        end
        m_cnt[i]  <= nc;
        m_en[i]   <= ne;
        m_pend[i] <= np;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (chk_irq) chk("R9 irq vs model", {24'h0, irq}, {24'h0, m_pend});
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic [31:0] exp_fr [5];
    logic [31:0] exp_pr [7];
    void'($urandom(32'd20240611));
    exp_fr = '{32'd2, 32'd1, 32'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFE};
    exp_pr = '{32'd3, 32'd2, 32'd1, 32'd3, 32'd2, 32'd1, 32'd3};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", {24'h0, irq}, 32'h0);
    rd(8'h00, d); chk("R1 ctrl0 after reset", d, 32'h0);
    rd(8'h3C, d); chk("R1 count7 after reset", d, 32'h0);
    rd(8'h40, d); chk("R1 status after reset", d, 32'h0);

    // R6 free-run wrap on channel 1
    wr(8'h0C, 32'd2);
    wr(8'h08, 32'h01);
    for (int k = 0; k < 5; k++) begin
      rd(8'h0C, d); chk("R6 free-run sequence", d, exp_fr[k]);
    end
    chk("R6 expiry sets irq1", {31'h0, irq[1]}, 32'd1);

    // R4 count write while running
    wr(8'h0C, 32'd100);
    rd(8'h0C, d); chk("R4 live reload while enabled", d, 32'd100);

    // R5 stopped channel holds
    wr(8'h08, 32'h0);
    rd(8'h0C, d);
    rd(8'h0C, d2); chk("R5 disabled counter holds", d2, d);

    // R7 one-shot on channel 2
    wr(8'h14, 32'd3);
    wr(8'h10, 32'h11);
    idle(6);
    rd(8'h10, d); chk("R7 one-shot clears enable", d, 32'h10);
    rd(8'h14, d); chk("R7 one-shot holds zero", d, 32'h0);
    chk("R9 one-shot irq2 pending", {31'h0, irq[2]}, 32'd1);

    // R8 periodic on channel 3
    wr(8'h1C, 32'd3);
    wr(8'h18, 32'h21);
    for (int k = 0; k < 7; k++) begin
      rd(8'h1C, d); chk("R8 periodic sequence", d, exp_pr[k]);
    end
    chk("R8 periodic irq3 pending", {31'h0, irq[3]}, 32'd1);
    wr(8'h18, 32'h0);

    // R9 selective clear
    wr(8'h40, 32'h04);
    chk("R9 irq2 cleared", {31'h0, irq[2]}, 32'd0);
    chk("R9 irq1 untouched by clear", {31'h0, irq[1]}, 32'd1);
    wr(8'h40, 32'h0A);
    rd(8'h40, d); chk("R9 status after clears", d, 32'h0);

    // R3 control byte fields
    wr(8'h28, 32'hFFFF_FF31);
    rd(8'h28, d); chk("R3 control readback masks", d, 32'h31);
    wr(8'h28, 32'h0000_000E);
    rd(8'h28, d); chk("R3 only en and mode kept", d, 32'h0);

    // R2 decode
    wr(8'h3C, 32'd9);
    rd(8'h3C, d); chk("R2 channel7 count", d, 32'd9);
    rd(8'h44, d); chk("R2 unmapped 0x44", d, 32'h0);
    rd(8'h06, d); chk("R2 misaligned 0x06", d, 32'h0);
    rd(8'h80, d); chk("R2 unmapped 0x80", d, 32'h0);
    rd(8'hFC, d); chk("R2 unmapped 0xFC", d, 32'h0);

    // Random traffic against the model (R2..R9)
    chk_irq = 1'b1;
    for (int n = 0; n < 3000; n++) begin
      int op;
      int ch;
      op = $urandom_range(0, 9);
      ch = $urandom_range(0, 7);
      case (op)
        0, 1: begin
          logic [31:0] v;
          case ($urandom_range(0, 5))
            0:       v = 32'hFFFF_FFFF;
            1:       v = $urandom();
            default: v = $urandom_range(0, 12);
          endcase
          wr(8'(ch*8+4), v);
        end
        2, 3: wr(8'(ch*8), {$urandom_range(0, 2**24-1), 2'($urandom_range(0, 3)),
                            3'($urandom_range(0, 7)), 1'($urandom_range(0, 1))});
        4:    wr(8'h40, 32'($urandom_range(0, 255)));
        5, 6: begin
          rd(8'(ch*8 + 4*$urandom_range(0, 1)), d);
          chk("R5 random channel read", d, m_rd);
        end
        7: begin
          rd(8'h40, d); chk("R9 random status read", d, m_rd);
        end
        8: begin
          rd(8'($urandom_range(0, 255)), d); chk("R2 random address read", d, m_rd);
        end
        default: idle($urandom_range(1, 4));
      endcase
    end
    chk_irq = 1'b0;
    done = 1'b1;
    summary();
  end
endmodule